// File: doc/BRIEF.md
# Compare/Capture PWM Timer Channel

This block is one timer channel. A 16-bit up-counter advances on count-enable strobes supplied by an external clock controller. Two value registers, A and B, sit beside the counter. In compare mode, B sets the period: the counter returns to zero on the strobe that finds it at B. A sets the duty: the PWM output rises after the strobe that finds the counter at A and falls at the B wrap. Both matches raise their own sticky interrupt flags. Software can load new compare values straight into the active registers, or hold them in a shadow copy that takes effect only at the next B wrap, so that a period is never torn.

In capture mode the same two registers become latches. Two external trigger pins are synchronized, edge-detected with a selectable polarity, and copy the running count into A or B. A capture that lands while the previous one in that register is still unread raises an overrun flag. A small word-addressed write/read port replaces a bus interface. The single interrupt line is the OR of every flag whose enable is set.

Top module: `ccp_timer_chan`

## Requirements
- R1: After reset the count reads 0, every flag reads 0, the PWM output is low and the interrupt line is low.
- R2: The count rises by exactly one on each clock with `cnt_en` high while the run bit (CTRL bit 0, address 0) is 1. With run at 0 it holds its value.
- R3: Writing CTRL with bit 6 set clears the count to 0 on that clock edge. Bit 6 does not stay set.
- R4: In compare mode (CTRL bit 1 = 0), a count strobe that finds the count at or above the active B value (address 2) returns the count to 0, so the period is B+1 strobes. B = 0 gives a period of one strobe.
- R5: In compare mode with A (address 1) below B, the raw PWM level goes high after the strobe at count A and low after the B wrap, so it is high for B-A strobes per period. A ≥ B keeps it low for the whole period. CTRL bit 3 inverts the output. While run is 0 the output rests at the value of bit 3.
- R6: With CTRL bit 2 = 0, writes to addresses 1 and 2 take effect at once. With bit 2 = 1 they go to a shadow copy that moves into the active register at the next B wrap. Reads of addresses 1 and 2 return the active values.
- R7: In capture mode (CTRL bit 1 = 1), an edge on `trig_a` or `trig_b` latches the count into A or B and sets the matching flag. CTRL bits 5:4 select the edge: 00 none, 01 rising, 10 falling, 11 both. Other edges are ignored.
- R8: A capture into a register that has not been read since its previous capture sets the overrun flag. A read is `rd_en` with `rd_addr` 1 or 2.
- R9: The flags at address 3 are bit 0 A match, bit 1 B wrap, bit 2 capture A, bit 3 capture B and bit 4 overrun. Each stays set until a write of 1 to that bit. A set in the same cycle wins over the clear.
- R10: `irq` is high exactly when some flag is set and its enable bit at address 4 (same bit order) is 1.
- R11: Address 5 reads the current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count strobe from the clock controller |
| trig_a | input | 1 | Asynchronous capture trigger for register A |
| trig_b | input | 1 | Asynchronous capture trigger for register B |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_en | input | 1 | Read acknowledge; marks a capture register as read |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Read data for `rd_addr`, combinational |
| pwm_out | output | 1 | PWM waveform |
| irq | output | 1 | Interrupt request |

## Verification
If the count or the active compare values go wrong, the PWM high time per period changes, so a whole-period duty measurement catches the fault within one period. A shadow value that moves too early or too late shows on the first read of B after a controlled number of strobes. Capture and overrun faults show as a wrong latched count or a wrong overrun bit, four clocks after the trigger edge. Flag and enable errors show on `irq` in the cycle after the event or the clearing write.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMPA  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMPB  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_FLAGS = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_IEN   = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_COUNT = 3'd5;

  localparam int CTRL_W  = 6;
  localparam int C_RUN   = 0;
  localparam int C_CAP   = 1;
  localparam int C_BUF   = 2;
  localparam int C_INV   = 3;
  localparam int C_EDGE  = 4;
  localparam int C_SWCLR = 6;

  localparam int NFLAG  = 5;
  localparam int F_CMPA = 0;
  localparam int F_CMPB = 1;
  localparam int F_CAPA = 2;
  localparam int F_CAPB = 3;
  localparam int F_OVR  = 4;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/ccp_counter.sv
module ccp_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         cnt_en,
  input  logic         cmp_mode,
  input  logic         sw_clr,
  input  logic [W-1:0] period,
  output logic [W-1:0] count,
  output logic         tick,
  output logic         wrap
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         at_end;

  assign tick   = run & cnt_en;
  assign at_end = cmp_mode & (cnt_q >= period);
  assign wrap   = tick & at_end & ~sw_clr;

  always_comb begin
    cnt_d = cnt_q;
    if (sw_clr)
      cnt_d = '0;
    else if (tick) begin
      if (at_end)
        cnt_d = '0;
      else
        cnt_d = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/ccp_capture.sv
module ccp_capture
  import ccp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      trig,
  input  logic      enable,
  input  edge_sel_e edge_sel,
  output logic      cap_ev
);
  logic s1_q, s2_q, prev_q;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= trig;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign rise = s2_q & ~prev_q;
  assign fall = ~s2_q & prev_q;

  always_comb begin
    cap_ev = 1'b0;
    if (enable) begin
      unique case (edge_sel)
        EDGE_RISE: cap_ev = rise;
        EDGE_FALL: cap_ev = fall;
        EDGE_BOTH: cap_ev = rise | fall;
        default:   cap_ev = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/ccp_pwm.sv
module ccp_pwm (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic inv,
  input  logic sw_clr,
  input  logic set_ev,
  input  logic clr_ev,
  output logic pwm_out
);
  logic raw_q, raw_d;

  always_comb begin
    raw_d = raw_q;
    if (!run || sw_clr || clr_ev)
      raw_d = 1'b0;
    else if (set_ev)
      raw_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      raw_q <= 1'b0;
    else
      raw_q <= raw_d;
  end

  assign pwm_out = run ? (raw_q ^ inv) : inv;
endmodule

// File: rtl/ccp_timer_chan.sv
module ccp_timer_chan
  import ccp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              trig_a,
  input  logic              trig_b,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [W-1:0]      rd_data,
  output logic              pwm_out,
  output logic              irq
);
  localparam int NREG = 2;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rsync_q <= 2'b00;
    else
      rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  // control register
  logic              wr_ctrl, wr_flags, wr_ien;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [NFLAG-1:0]  ien_q, ien_d;
  logic              run, cmp_mode, buf_en, inv, sw_clr;
  edge_sel_e         edge_sel;

  assign wr_ctrl  = wr_en & (wr_addr == ADDR_CTRL);
  assign wr_flags = wr_en & (wr_addr == ADDR_FLAGS);
  assign wr_ien   = wr_en & (wr_addr == ADDR_IEN);
  assign sw_clr   = wr_ctrl & wr_data[C_SWCLR];

  always_comb begin
    ctrl_d = wr_ctrl ? wr_data[CTRL_W-1:0] : ctrl_q;
    ien_d  = wr_ien  ? wr_data[NFLAG-1:0]  : ien_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ctrl_q <= '0;
      ien_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      ien_q  <= ien_d;
    end
  end

  assign run      = ctrl_q[C_RUN];
  assign cmp_mode = ~ctrl_q[C_CAP];
  assign buf_en   = ctrl_q[C_BUF];
  assign inv      = ctrl_q[C_INV];
  assign edge_sel = edge_sel_e'(ctrl_q[C_EDGE+1:C_EDGE]);

  // counter
  logic [W-1:0] count;
  logic [W-1:0] act_w [NREG];
  logic [W-1:0] period;
  logic         tick, wrap;

  assign period = act_w[1];

  ccp_counter #(.W(W)) u_cnt (
    .clk      (clk),
    .rst_n    (srst_n),
    .run      (run),
    .cnt_en   (cnt_en),
    .cmp_mode (cmp_mode),
    .sw_clr   (sw_clr),
    .period   (period),
    .count    (count),
    .tick     (tick),
    .wrap     (wrap)
  );

  // A/B registers: compare values or capture latches
  logic [NREG-1:0] trig_in;
  logic [NREG-1:0] cap_ev;
  logic [NREG-1:0] full_w;
  assign trig_in = {trig_b, trig_a};

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [ADDR_W-1:0] MY_ADDR = (i == 0) ? ADDR_CMPA : ADDR_CMPB;
    logic [W-1:0] act_q, act_d, shd_q, shd_d;
    logic         full_q, full_d;
    logic         wr_me, rd_me;

    assign wr_me = wr_en & (wr_addr == MY_ADDR);
    assign rd_me = rd_en & (rd_addr == MY_ADDR);

    ccp_capture u_cap (
      .clk      (clk),
      .rst_n    (srst_n),
      .trig     (trig_in[i]),
      .enable   (~cmp_mode),
      .edge_sel (edge_sel),
      .cap_ev   (cap_ev[i])
    );

    always_comb begin
      act_d  = act_q;
      shd_d  = wr_me ? wr_data : shd_q;
      full_d = full_q;
      if (cap_ev[i])
        act_d = count;
      else if (wr_me && !buf_en)
        act_d = wr_data;
      else if (wrap && buf_en)
        act_d = shd_q;
      if (cap_ev[i])
        full_d = 1'b1;
      else if (rd_me)
        full_d = 1'b0;
    end

    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n) begin
        act_q  <= '0;
        shd_q  <= '0;
        full_q <= 1'b0;
      end else begin
        act_q  <= act_d;
        shd_q  <= shd_d;
        full_q <= full_d;
      end
    end

    assign act_w[i]  = act_q;
    assign full_w[i] = full_q;
  end

  // compare-A event: only when A lies inside the period
  logic a_hit;
  assign a_hit = tick & cmp_mode & ~sw_clr & (count == act_w[0]) & (act_w[0] < act_w[1]);

  ccp_pwm u_pwm (
    .clk     (clk),
    .rst_n   (srst_n),
    .run     (run),
    .inv     (inv),
    .sw_clr  (sw_clr),
    .set_ev  (a_hit),
    .clr_ev  (wrap),
    .pwm_out (pwm_out)
  );

  // interrupt flags
  logic [NFLAG-1:0] ev, flags_q, flags_d, clr_mask;
  always_comb begin
    ev         = '0;
    ev[F_CMPA] = a_hit;
    ev[F_CMPB] = wrap;
    ev[F_CAPA] = cap_ev[0];
    ev[F_CAPB] = cap_ev[1];
    ev[F_OVR]  = |(cap_ev & full_w);
    clr_mask   = wr_flags ? wr_data[NFLAG-1:0] : '0;
    flags_d    = (flags_q & ~clr_mask) | ev;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)
      flags_q <= '0;
    else
      flags_q <= flags_d;
  end

  assign irq = |(flags_q & ien_q);

  // read mux
  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      ADDR_CTRL:  rd_data = W'(ctrl_q);
      ADDR_CMPA:  rd_data = act_w[0];
      ADDR_CMPB:  rd_data = act_w[1];
      ADDR_FLAGS: rd_data = W'(flags_q);
      ADDR_IEN:   rd_data = W'(ien_q);
      ADDR_COUNT: rd_data = count;
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/ccp_timer_chan_chk.sv
module ccp_timer_chan_chk
  import ccp_pkg::*;
#(
  parameter int W = 16
) (
  input logic              clk,
  input logic              srst_n,
  input logic              run,
  input logic              inv,
  input logic              cnt_en,
  input logic              sw_clr,
  input logic              cmp_mode,
  input logic [W-1:0]      count,
  input logic [W-1:0]      period,
  input logic              pwm_out,
  input logic [NFLAG-1:0]  flags,
  input logic [1:0]        cap_full,
  input logic [1:0]        cap_ev,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [W-1:0]      wr_data
);
  logic [NFLAG-1:0] chk_clr;
  assign chk_clr = (wr_en && wr_addr == ADDR_FLAGS) ? wr_data[NFLAG-1:0] : '0;

  assert_idle_level_R5: assert property (@(posedge clk) disable iff (!srst_n)
    !run |-> (pwm_out == inv));

  assert_hold_count_R2: assert property (@(posedge clk) disable iff (!srst_n)
    (!(run && cnt_en) && !sw_clr) |=> $stable(count));

  assert_free_step_R2: assert property (@(posedge clk) disable iff (!srst_n)
    (run && cnt_en && !sw_clr && !cmp_mode) |=> (count == $past(count) + W'(1)));

  assert_swclr_R3: assert property (@(posedge clk) disable iff (!srst_n)
    sw_clr |=> (count == '0));

  assert_period_wrap_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (run && cnt_en && cmp_mode && (count >= period)) |=> (count == '0));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!srst_n)
    1'b1 |=> ((($past(flags) & ~$past(chk_clr)) & ~flags) == '0));

  assert_overrun_R8: assert property (@(posedge clk) disable iff (!srst_n)
    (|(cap_ev & cap_full)) |=> flags[F_OVR]);
endmodule

bind ccp_timer_chan ccp_timer_chan_chk #(.W(W)) u_chk (
  .clk      (clk),
  .srst_n   (srst_n),
  .run      (run),
  .inv      (inv),
  .cnt_en   (cnt_en),
  .sw_clr   (sw_clr),
  .cmp_mode (cmp_mode),
  .count    (count),
  .period   (period),
  .pwm_out  (pwm_out),
  .flags    (flags_q),
  .cap_full (full_w),
  .cap_ev   (cap_ev),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data)
);

// File: tb/ccp_timer_chan_test.sv
module ccp_timer_chan_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  localparam logic [2:0] A_CTRL = 3'd0, A_CMPA = 3'd1, A_CMPB = 3'd2,
                         A_FLAGS = 3'd3, A_IEN = 3'd4, A_COUNT = 3'd5;
  localparam int RUN = 1, CAPM = 2, BUFM = 4, INVM = 8, ERISE = 16, EFALL = 32, SWCLR = 64;

  // A, B, invert, expected high strobes per period
  localparam int NV = 8;
  localparam int VEC [NV][4] = '{
    '{2, 5, 0, 3}, '{0, 3, 0, 3}, '{3, 3, 0, 0}, '{7, 4, 0, 0},
    '{1, 0, 0, 0}, '{2, 5, 1, 3}, '{0, 0, 1, 1}, '{4, 9, 0, 5}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0, trig_a = 1'b0, trig_b = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        pwm_out, irq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [15:0] v;

  ccp_timer_chan uut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .trig_a(trig_a), .trig_b(trig_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .pwm_out(pwm_out), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG) begin
      fails = fails + 1;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_addr = a; rd_en = 1'b1;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulses(input int n);
    @(negedge clk);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 pwm_out", int'(pwm_out), 0);
    check("R1 irq", int'(irq), 0);
    rd(A_COUNT, v); check("R1 count", int'(v), 0);
    rd(A_FLAGS, v); check("R1 flags", int'(v), 0);

    // R5 duty table, R4 period length
    for (int k = 0; k < NV; k++) begin
      int hi;
      int per;
      per = VEC[k][1] + 1;
      wr(A_CTRL, 0);
      wr(A_CMPA, VEC[k][0]);
      wr(A_CMPB, VEC[k][1]);
      wr(A_CTRL, RUN | SWCLR | (VEC[k][2] != 0 ? INVM : 0));
      cnt_en = 1'b1;
      repeat (2 * per) @(negedge clk);
      hi = 0;
      for (int c = 0; c < 3 * per; c++) begin
        @(negedge clk);
        if (pwm_out) hi = hi + 1;
      end
      cnt_en = 1'b0;
      check($sformatf("R5 high time vector %0d", k), hi, 3 * VEC[k][3]);
    end

    // R5 idle level and R2 hold while stopped
    wr(A_CTRL, INVM);
    #1 check("R5 idle level inverted", int'(pwm_out), 1);
    wr(A_CTRL, 0);
    #1 check("R5 idle level", int'(pwm_out), 0);
    rd(A_COUNT, v);
    begin
      logic [15:0] held;
      held = v;
      pulses(5);
      rd(A_COUNT, v); check("R2 count held while stopped", int'(v), int'(held));
    end

    // R2 counting, R3 software clear, R11 count readout
    wr(A_CMPA, 50); wr(A_CMPB, 100);
    wr(A_CTRL, RUN | SWCLR);
    pulses(10);
    rd(A_COUNT, v); check("R2 R11 count after 10 strobes", int'(v), 10);
    wr(A_CTRL, RUN | SWCLR);
    rd(A_COUNT, v); check("R3 count cleared", int'(v), 0);
    rd(A_CTRL, v); check("R3 clear bit not kept", int'(v), RUN);

    // R4 wrap, R9 flags, R10 irq
    wr(A_CTRL, 0);
    wr(A_CMPA, 1); wr(A_CMPB, 4);
    wr(A_FLAGS, 31);
    wr(A_IEN, 2);
    wr(A_CTRL, RUN | SWCLR);
    pulses(4);
    rd(A_COUNT, v); check("R4 count before wrap", int'(v), 4);
    check("R10 irq before B wrap", int'(irq), 0);
    pulses(1);
    rd(A_COUNT, v); check("R4 count after wrap", int'(v), 0);
    check("R10 irq after B wrap", int'(irq), 1);
    wr(A_CTRL, 0);
    rd(A_FLAGS, v); check("R9 A and B flags", int'(v), 3);
    wr(A_FLAGS, 2);
    rd(A_FLAGS, v); check("R9 selective clear", int'(v), 1);
    check("R10 irq with masked flag only", int'(irq), 0);
    wr(A_CMPB, 0);
    wr(A_CTRL, RUN | SWCLR);
    pulses(3);
    rd(A_COUNT, v); check("R4 B zero period", int'(v), 0);

    // R6 buffered compare values
    wr(A_CTRL, 0);
    wr(A_CMPA, 2); wr(A_CMPB, 5);
    rd(A_CMPB, v); check("R6 direct write", int'(v), 5);
    wr(A_CTRL, BUFM);
    wr(A_CMPB, 9);
    rd(A_CMPB, v); check("R6 shadow not yet active", int'(v), 5);
    wr(A_CTRL, BUFM | RUN | SWCLR);
    pulses(3);
    rd(A_CMPB, v); check("R6 mid-period still old", int'(v), 5);
    pulses(3);
    rd(A_CMPB, v); check("R6 loaded at wrap", int'(v), 9);

    // R7 capture, R8 overrun
    wr(A_CTRL, 0);
    wr(A_FLAGS, 31);
    wr(A_IEN, 0);
    wr(A_CTRL, CAPM | RUN | SWCLR | ERISE);
    pulses(7);
    @(negedge clk) trig_a = 1'b1;
    settle();
    rd(A_CMPA, v); check("R7 rising capture A", int'(v), 7);
    rd(A_FLAGS, v); check("R7 capture A flag", int'(v), 4);
    @(negedge clk) trig_a = 1'b0;
    settle();
    pulses(3);
    @(negedge clk) trig_a = 1'b1;
    settle();
    rd(A_FLAGS, v); check("R8 no overrun after read", int'(v[4]), 0);
    @(negedge clk) trig_a = 1'b0;
    settle();
    @(negedge clk) trig_a = 1'b1;
    settle();
    rd(A_FLAGS, v); check("R8 overrun set", int'(v[4]), 1);
    rd(A_CMPA, v); check("R7 second capture value", int'(v), 10);

    wr(A_FLAGS, 31);
    wr(A_CTRL, CAPM | RUN | EFALL);
    @(negedge clk) trig_b = 1'b1;
    settle();
    rd(A_FLAGS, v); check("R7 rising edge ignored", int'(v), 0);
    rd(A_CMPB, v); check("R7 B unchanged", int'(v), 9);
    @(negedge clk) trig_b = 1'b0;
    settle();
    rd(A_FLAGS, v); check("R7 falling capture B flag", int'(v), 8);
    rd(A_CMPB, v); check("R7 falling capture B value", int'(v), 10);

    wr(A_IEN, 8);
    #1 check("R10 irq on capture B", int'(irq), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule